// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits on the memory side of a hierarchical cache system and keeps one directory entry for each address it owns. Each entry is shared, listing the children that hold read-only copies as a bit mask, or exclusive, naming the single child that holds a writable copy. Two transient forms cover the time while invalidations or a data return are outstanding. The home also keeps the memory data for each address, and it replaces that data when a child returns a dirty copy.

Children send one message per cycle on a single input channel. A message is either a request (shared or exclusive) or a reply (invalidate acknowledgement, write-back or flush carrying data). The controller answers on a registered output channel one cycle later. It sends grants, invalidate requests to a sharer mask, a write-back or flush demand to the owner, or a retry to a child whose request hit a busy entry. When a request needs other caches to act first, it is parked in the entry. The reply that ends the transient state then completes the request in the same cycle.

Top module: `home_dir_ctrl`

## Requirements
- R1: After a synchronous active-high reset every entry is shared with an empty sharer mask, all memory data is zero, and `out_valid` and `proto_err` are low. Any cycle with `in_valid` low gives `out_valid` low and `proto_err` low one cycle later.
- R2: Input kinds are 0 shared request, 1 exclusive request, 2 invalidate reply, 3 write-back reply and 4 flush reply. Output kinds are 0 shared grant, 1 exclusive grant, 2 invalidate request, 3 write-back request, 4 flush request and 5 retry. `out_dst` is a mask with bit i standing for child i. A shared request to a shared entry adds the sender to the mask and answers, one cycle later, with a shared grant to the sender carrying the memory data.
- R3: An exclusive request to a shared entry whose mask holds no child other than the sender answers with an exclusive grant carrying the memory data. The entry becomes exclusive, owned by the sender.
- R4: An exclusive request to a shared entry with other sharers sends one invalidate request whose mask is the sharer mask without the sender. The entry enters the transient shared form. The invalidate reply that leaves no sharer other than the parked requester produces, in that same cycle, an exclusive grant to the requester, and the requester becomes owner.
- R5: An invalidate reply to a shared or transient-shared entry removes the sender from the mask, even if it was not in it. It produces no output unless it completes R4.
- R6: A shared request to an exclusive entry sends a write-back request to the owner and parks the requester. The owner's write-back reply stores its data and leaves a shared entry holding the old owner and the requester. In that same cycle it sends a shared grant to the requester carrying the returned data.
- R7: An exclusive request to an exclusive entry sends a flush request to the owner and parks the requester. The owner's flush reply stores its data and empties the mask. In that same cycle it grants exclusive access, carrying the returned data, to the requester, which becomes owner.
- R8: A write-back reply from the owner of an exclusive entry with nothing parked stores the data and leaves the entry shared by the old owner alone. A flush reply in the same case stores the data and leaves the entry shared with an empty mask. Neither produces an output message.
- R9: A write-back or flush reply to a shared or transient-shared entry, or from a child that is not the owner, raises `proto_err` for one cycle. So does an invalidate reply to an exclusive or transient-exclusive entry. In each case no output message is sent, and the entry and its data are left unchanged.
- R10: A request to an entry in either transient form is answered with a retry to the sender and changes nothing.
- R11: Entries of different addresses are independent. Grants carry data in `out_data`, and every other output kind carries zero there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message is present this cycle |
| in_kind | input | 3 | Message kind (see R2) |
| in_src | input | $clog2(N_CHILD) | Sending child number |
| in_addr | input | ADDR_W | Address the message concerns |
| in_data | input | DATA_W | Data carried by write-back and flush replies |
| out_valid | output | 1 | An output message is present |
| out_kind | output | 3 | Output message kind (see R2) |
| out_dst | output | N_CHILD | Destination children mask |
| out_addr | output | ADDR_W | Address of the output message |
| out_data | output | DATA_W | Data on grants, zero otherwise |
| proto_err | output | 1 | One-cycle pulse for a reply in an illegal state |

## Verification
The functions that coincide are the store of returned data, the exit from a transient state, and the release of the parked request. A write-back or flush reply writes memory and, in the same cycle, grants the waiting child. The bench provokes this by parking a shared request and then an exclusive request behind an owner. It judges that the grant carries the freshly returned data rather than the stale memory value, and that a later read sees the same value. The final invalidate reply that both shrinks the mask and releases an exclusive grant is checked the same way, as is one that leaves the parked requester itself in the mask.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

  typedef enum logic [2:0] {
    IK_SH_REQ    = 3'd0,
    IK_EX_REQ    = 3'd1,
    IK_INV_REP   = 3'd2,
    IK_WB_REP    = 3'd3,
    IK_FLUSH_REP = 3'd4
  } in_kind_e;

  typedef enum logic [2:0] {
    OK_SH_GRANT  = 3'd0,
    OK_EX_GRANT  = 3'd1,
    OK_INV_REQ   = 3'd2,
    OK_WB_REQ    = 3'd3,
    OK_FLUSH_REQ = 3'd4,
    OK_RETRY     = 3'd5
  } out_kind_e;

  typedef enum logic [1:0] {
    DS_SHARED  = 2'd0,
    DS_EXCL    = 2'd1,
    DS_T_SHARE = 2'd2,
    DS_T_EXCL  = 2'd3
  } dir_state_e;

endpackage

// File: rtl/home_dir_store.sv
module home_dir_store #(
  parameter int AW     = 4,
  parameter int ENT_W  = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  output logic [ENT_W-1:0]  rd_ent,
  output logic [DATA_W-1:0] rd_dat,
  input  logic              we_ent,
  input  logic [ENT_W-1:0]  wr_ent,
  input  logic              we_dat,
  input  logic [DATA_W-1:0] wr_dat
);
  localparam int DEPTH = 1 << AW;

  logic [ENT_W-1:0]  ent_mem [DEPTH];
  logic [DATA_W-1:0] dat_mem [DEPTH];

  assign rd_ent = ent_mem[addr];
  assign rd_dat = dat_mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_mem[i] <= '0;
        dat_mem[i] <= '0;
      end
    end else begin
      if (we_ent) ent_mem[addr] <= wr_ent;
      if (we_dat) dat_mem[addr] <= wr_dat;
    end
  end
endmodule

// File: rtl/home_dir_next.sv
module home_dir_next
  import home_dir_pkg::*;
#(
  parameter int N_CHILD = 8,
  parameter int DATA_W  = 32,
  parameter int IW      = 3,
  parameter int ENT_W   = 2 + 8 + 2*3 + 1
) (
  input  logic               in_valid,
  input  logic [2:0]         in_kind,
  input  logic [IW-1:0]      in_src,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [ENT_W-1:0]   cur_ent,
  input  logic [DATA_W-1:0]  cur_dat,
  output logic               we_ent,
  output logic [ENT_W-1:0]   nxt_ent,
  output logic               we_dat,
  output logic               o_valid,
  output logic [2:0]         o_kind,
  output logic [N_CHILD-1:0] o_dst,
  output logic [DATA_W-1:0]  o_data,
  output logic               o_err
);
  localparam logic [N_CHILD-1:0] ONE = N_CHILD'(1);

  dir_state_e         st, n_st;
  logic [N_CHILD-1:0] sh, n_sh, src_b, own_b, pnd_b, others, base;
  logic [IW-1:0]      own, pnd, n_own, n_pnd;
  logic               pex, n_pex, owner_ok;

  assign st    = dir_state_e'(cur_ent[ENT_W-1 -: 2]);
  assign sh    = cur_ent[ENT_W-3 -: N_CHILD];
  assign own   = cur_ent[2*IW -: IW];
  assign pnd   = cur_ent[IW -: IW];
  assign pex   = cur_ent[0];
  assign src_b = ONE << in_src;
  assign own_b = ONE << own;
  assign pnd_b = ONE << pnd;
  assign owner_ok = (st == DS_EXCL || st == DS_T_EXCL) && (in_src == own);
  assign nxt_ent = {n_st, n_sh, n_own, n_pnd, n_pex};

  always_comb begin
    n_st = st; n_sh = sh; n_own = own; n_pnd = pnd; n_pex = pex;
    we_ent = 1'b0; we_dat = 1'b0;
    o_valid = 1'b0; o_kind = OK_SH_GRANT; o_dst = '0; o_data = '0; o_err = 1'b0;
    others = '0; base = '0;
    if (in_valid) begin
      case (in_kind)
        IK_SH_REQ, IK_EX_REQ: begin
          o_valid = 1'b1;
          if (st == DS_T_SHARE || st == DS_T_EXCL) begin
            o_kind = OK_RETRY; o_dst = src_b;
          end else if (st == DS_EXCL) begin
            we_ent = 1'b1; n_st = DS_T_EXCL; n_pnd = in_src;
            n_pex  = (in_kind == IK_EX_REQ);
            o_kind = n_pex ? OK_FLUSH_REQ : OK_WB_REQ;
            o_dst  = own_b;
          end else if (in_kind == IK_SH_REQ) begin
            we_ent = 1'b1; n_sh = sh | src_b;
            o_kind = OK_SH_GRANT; o_dst = src_b; o_data = cur_dat;
          end else begin
            we_ent = 1'b1;
            others = sh & ~src_b;
            if (others == '0) begin
              n_st = DS_EXCL; n_own = in_src; n_sh = '0;
              o_kind = OK_EX_GRANT; o_dst = src_b; o_data = cur_dat;
            end else begin
              n_st = DS_T_SHARE; n_pnd = in_src; n_pex = 1'b1;
              o_kind = OK_INV_REQ; o_dst = others;
            end
          end
        end
        IK_INV_REP: begin
          if (st == DS_SHARED) begin
            we_ent = 1'b1; n_sh = sh & ~src_b;
          end else if (st == DS_T_SHARE) begin
            we_ent = 1'b1; n_sh = sh & ~src_b;
            if ((n_sh & ~pnd_b) == '0) begin
              n_st = DS_EXCL; n_own = pnd; n_sh = '0;
              o_valid = 1'b1; o_kind = OK_EX_GRANT; o_dst = pnd_b; o_data = cur_dat;
            end
          end else begin
            o_err = 1'b1;
          end
        end
        IK_WB_REP, IK_FLUSH_REP: begin
          if (!owner_ok) begin
            o_err = 1'b1;
          end else begin
            we_ent = 1'b1; we_dat = 1'b1;
            base = (in_kind == IK_WB_REP) ? src_b : '0;
            n_st = DS_SHARED; n_sh = base;
            if (st == DS_T_EXCL) begin
              o_valid = 1'b1; o_data = in_data;
              if (!pex) begin
                n_sh = base | pnd_b;
                o_kind = OK_SH_GRANT; o_dst = pnd_b;
              end else begin
                others = base & ~pnd_b;
                if (others == '0) begin
                  n_st = DS_EXCL; n_own = pnd; n_sh = '0;
                  o_kind = OK_EX_GRANT; o_dst = pnd_b;
                end else begin
                  n_st = DS_T_SHARE;
                  o_kind = OK_INV_REQ; o_dst = others; o_data = '0;
                end
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
  parameter int N_CHILD = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [2:0]                 in_kind,
  input  logic [$clog2(N_CHILD)-1:0] in_src,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       out_valid,
  output logic [2:0]                 out_kind,
  output logic [N_CHILD-1:0]         out_dst,
  output logic [ADDR_W-1:0]          out_addr,
  output logic [DATA_W-1:0]          out_data,
  output logic                       proto_err
);
  localparam int IW    = $clog2(N_CHILD);
  localparam int ENT_W = 2 + N_CHILD + 2*IW + 1;

  logic [ENT_W-1:0]   cur_ent, nxt_ent;
  logic [DATA_W-1:0]  cur_dat, c_data;
  logic               we_ent, we_dat, c_valid, c_err;
  logic [2:0]         c_kind;
  logic [N_CHILD-1:0] c_dst;

  home_dir_store #(.AW(ADDR_W), .ENT_W(ENT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .addr(in_addr),
    .rd_ent(cur_ent), .rd_dat(cur_dat),
    .we_ent(we_ent), .wr_ent(nxt_ent),
    .we_dat(we_dat), .wr_dat(in_data)
  );

  home_dir_next #(.N_CHILD(N_CHILD), .DATA_W(DATA_W), .IW(IW), .ENT_W(ENT_W)) u_next (
    .in_valid(in_valid), .in_kind(in_kind), .in_src(in_src), .in_data(in_data),
    .cur_ent(cur_ent), .cur_dat(cur_dat),
    .we_ent(we_ent), .nxt_ent(nxt_ent), .we_dat(we_dat),
    .o_valid(c_valid), .o_kind(c_kind), .o_dst(c_dst), .o_data(c_data), .o_err(c_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_dst   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
      proto_err <= 1'b0;
    end else begin
      out_valid <= c_valid;
      out_kind  <= c_kind;
      out_dst   <= c_dst;
      out_addr  <= in_addr;
      out_data  <= c_data;
      proto_err <= c_err;
    end
  end
endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter int N_CHILD = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [2:0]                 in_kind,
  input logic [$clog2(N_CHILD)-1:0] in_src,
  input logic                       out_valid,
  input logic [2:0]                 out_kind,
  input logic [N_CHILD-1:0]         out_dst,
  input logic [DATA_W-1:0]          out_data,
  input logic                       proto_err
);
  // R1: an idle input cycle leaves the outputs quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !proto_err));

  // R2: point-to-point messages go to exactly one child
  a_r2_single_dst: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind != 3'd2) |-> $onehot(out_dst));

  // R4: an invalidate request always targets someone
  a_r4_inv_nonempty: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 3'd2) |-> (out_dst != '0));

  // R9: an error comes only from a reply and never with a message
  a_r9_err_from_reply: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (!out_valid && $past(in_valid && in_kind >= 3'd2 && in_kind <= 3'd4)));

  // R10: a retry answers the sender of a request
  a_r10_retry_to_sender: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 3'd5) |->
      ($past(in_valid && in_kind <= 3'd1) && out_dst == (N_CHILD'(1) << $past(in_src))));

  // R11: non-grant messages carry no data
  a_r11_nodata: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind >= 3'd2) |-> (out_data == '0));
endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_src(in_src),
  .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst), .out_data(out_data),
  .proto_err(proto_err)
);

// File: tb/test_home_dir_ctrl.sv
module test_home_dir_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [2:0]  in_src = '0;
  logic [3:0]  in_addr = '0;
  logic [31:0] in_data = '0;
  logic        out_valid, proto_err;
  logic [2:0]  out_kind;
  logic [7:0]  out_dst;
  logic [3:0]  out_addr;
  logic [31:0] out_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  home_dir_ctrl i_home_dir_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_src(in_src),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_kind(out_kind),
    .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data), .proto_err(proto_err)
  );

  // {req, kind, src, addr, data, exp_valid, exp_kind, exp_dst, exp_data, exp_err}
  localparam int NV = 25;
  localparam logic [90:0] VEC [NV] = '{
    {4'd2, 3'd0,3'd1,4'd0,32'h0,        1'b1,3'd0,8'h02,32'h0,        1'b0}, // R2
    {4'd2, 3'd0,3'd2,4'd0,32'h0,        1'b1,3'd0,8'h04,32'h0,        1'b0}, // R2
    {4'd4, 3'd1,3'd3,4'd0,32'h0,        1'b1,3'd2,8'h06,32'h0,        1'b0}, // R4
    {4'd10,3'd0,3'd4,4'd0,32'h0,        1'b1,3'd5,8'h10,32'h0,        1'b0}, // R10
    {4'd5, 3'd2,3'd1,4'd0,32'h0,        1'b0,3'd0,8'h00,32'h0,        1'b0}, // R5
    {4'd4, 3'd2,3'd2,4'd0,32'h0,        1'b1,3'd1,8'h08,32'h0,        1'b0}, // R4
    {4'd6, 3'd0,3'd5,4'd0,32'h0,        1'b1,3'd3,8'h08,32'h0,        1'b0}, // R6
    {4'd6, 3'd3,3'd3,4'd0,32'hAAAA1111, 1'b1,3'd0,8'h20,32'hAAAA1111, 1'b0}, // R6
    {4'd4, 3'd1,3'd5,4'd0,32'h0,        1'b1,3'd2,8'h08,32'h0,        1'b0}, // R4
    {4'd4, 3'd2,3'd3,4'd0,32'h0,        1'b1,3'd1,8'h20,32'hAAAA1111, 1'b0}, // R4
    {4'd7, 3'd1,3'd0,4'd0,32'h0,        1'b1,3'd4,8'h20,32'h0,        1'b0}, // R7
    {4'd7, 3'd4,3'd5,4'd0,32'h12345678, 1'b1,3'd1,8'h01,32'h12345678, 1'b0}, // R7
    {4'd9, 3'd3,3'd1,4'd0,32'hDEAD0001, 1'b0,3'd0,8'h00,32'h0,        1'b1}, // R9
    {4'd9, 3'd2,3'd0,4'd0,32'h0,        1'b0,3'd0,8'h00,32'h0,        1'b1}, // R9
    {4'd8, 3'd4,3'd0,4'd0,32'h0BADF00D, 1'b0,3'd0,8'h00,32'h0,        1'b0}, // R8
    {4'd8, 3'd0,3'd6,4'd0,32'h0,        1'b1,3'd0,8'h40,32'h0BADF00D, 1'b0}, // R8
    {4'd3, 3'd1,3'd6,4'd0,32'h0,        1'b1,3'd1,8'h40,32'h0BADF00D, 1'b0}, // R3
    {4'd8, 3'd3,3'd6,4'd0,32'h00000055, 1'b0,3'd0,8'h00,32'h0,        1'b0}, // R8
    {4'd9, 3'd3,3'd6,4'd0,32'h00000066, 1'b0,3'd0,8'h00,32'h0,        1'b1}, // R9
    {4'd9, 3'd0,3'd7,4'd0,32'h0,        1'b1,3'd0,8'h80,32'h00000055, 1'b0}, // R9
    {4'd11,3'd0,3'd2,4'd1,32'h0,        1'b1,3'd0,8'h04,32'h0,        1'b0}, // R11
    {4'd5, 3'd2,3'd5,4'd1,32'h0,        1'b0,3'd0,8'h00,32'h0,        1'b0}, // R5
    {4'd11,3'd1,3'd2,4'd1,32'h0,        1'b1,3'd1,8'h04,32'h0,        1'b0}, // R11
    {4'd5, 3'd2,3'd7,4'd0,32'h0,        1'b0,3'd0,8'h00,32'h0,        1'b0}, // R5
    {4'd5, 3'd1,3'd6,4'd0,32'h0,        1'b1,3'd1,8'h40,32'h00000055, 1'b0}  // R5
  };

  task automatic check(input string tag, input logic ev, input logic [2:0] ek,
                       input logic [7:0] ed, input logic [31:0] edat, input logic ee);
    total++;
    if (out_valid !== ev || proto_err !== ee || out_dst !== ed || out_data !== edat ||
        (ev && out_kind !== ek)) begin
      bad++;
      $display("FAIL %s: got v=%0b k=%0d dst=%h data=%h err=%0b, want v=%0b k=%0d dst=%h data=%h err=%0b",
               tag, out_valid, out_kind, out_dst, out_data, proto_err, ev, ek, ed, edat, ee);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [2:0] s, input logic [3:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_src = s; in_addr = a; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no finish, want finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs during reset", 1'b0, 3'd0, 8'h00, 32'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
    idle();
    check("R1 idle after reset", 1'b0, 3'd0, 8'h00, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [90:0] v;
      v = VEC[i];
      send(v[86:84], v[83:81], v[80:77], v[76:45]);
      check($sformatf("R%0d vector %0d", v[90:87], i), v[44], v[43:41], v[40:33], v[32:1], v[0]);
    end

    // R9: error is a single-cycle pulse
    send(3'd4, 3'd3, 4'd2, 32'h1);
    check("R9 illegal flush", 1'b0, 3'd0, 8'h00, 32'h0, 1'b1);
    idle();
    check("R9 pulse clears", 1'b0, 3'd0, 8'h00, 32'h0, 1'b0);
    // R9: data of address 2 untouched by the illegal flush
    send(3'd0, 3'd3, 4'd2, 32'h0);
    check("R9 data unchanged", 1'b1, 3'd0, 8'h08, 32'h0, 1'b0);

    // R6 and R4: write-back leaves the owner sharing, parked exclusive becomes invalidate
    send(3'd1, 3'd1, 4'd3, 32'h0);
    check("R3 grant addr3", 1'b1, 3'd1, 8'h02, 32'h0, 1'b0);
    send(3'd1, 3'd4, 4'd3, 32'h0);
    check("R7 flush demand addr3", 1'b1, 3'd4, 8'h02, 32'h0, 1'b0);
    send(3'd3, 3'd1, 4'd3, 32'h00C0FFEE);
    check("R4 wb answered with invalidate", 1'b1, 3'd2, 8'h02, 32'h0, 1'b0);
    send(3'd2, 3'd1, 4'd3, 32'h0);
    check("R4 final inv grants", 1'b1, 3'd1, 8'h10, 32'h00C0FFEE, 1'b0);

    // R4: requester already a sharer is not invalidated
    send(3'd0, 3'd1, 4'd4, 32'h0);
    check("R2 sharer 1 addr4", 1'b1, 3'd0, 8'h02, 32'h0, 1'b0);
    send(3'd0, 3'd2, 4'd4, 32'h0);
    check("R2 sharer 2 addr4", 1'b1, 3'd0, 8'h04, 32'h0, 1'b0);
    send(3'd1, 3'd1, 4'd4, 32'h0);
    check("R4 inv excludes requester", 1'b1, 3'd2, 8'h04, 32'h0, 1'b0);
    send(3'd2, 3'd2, 4'd4, 32'h0);
    check("R4 grant with requester left", 1'b1, 3'd1, 8'h02, 32'h0, 1'b0);

    // R1: reset mid-run clears directory and data
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send(3'd0, 3'd1, 4'd0, 32'h0);
    check("R1 data cleared", 1'b1, 3'd0, 8'h02, 32'h0, 1'b0);
    send(3'd1, 3'd2, 4'd0, 32'h0);
    check("R1 mask cleared", 1'b1, 3'd2, 8'h02, 32'h0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule